// File: doc/BRIEF.md
# Interrupt State, Enable and Test Register Block

This block keeps the interrupt bookkeeping for a serial peripheral that raises four kinds of event: transmit watermark, receive watermark, transmit empty and receive overflow. Each one-cycle event pulse from the datapath latches a sticky pending bit. Software sees these bits through a small word-addressed register window and clears them by writing ones. A write-only test register lets software raise pending bits on purpose. A mask register decides which pending bits reach the four level-sensitive interrupt lines.

The block sits on a simple 32-bit register bus with separate read and write strobes. A read returns its data in the cycle after the read strobe. Each interrupt line is the AND of its pending bit and its mask bit. It follows the registers directly, so it changes in the cycle after any write or event that alters either of them.

Top module: `irq_state_regs`

## Requirements
- R1: After reset the pending register and the mask register are zero, all interrupt lines are low and the read data is zero.
- R2: A high level on event input bit i in a cycle sets pending bit i, and the bit stays set after the event drops. Bit 0 is transmit watermark, bit 1 is receive watermark, bit 2 is transmit empty and bit 3 is receive overflow.
- R3: A write to offset 0x0 (pending) clears each pending bit whose written data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x8 (test) sets each pending bit whose written data bit is 1 and leaves the other bits unchanged.
- R5: Interrupt line i is high exactly when pending bit i and mask bit i are both set. The line is valid in the cycle after the write or event that changed either bit.
- R6: A write to offset 0x4 (mask) replaces all four mask bits with data bits 3:0.
- R7: A read of offset 0x0 or 0x4 returns the pending or mask bits in data bits 3:0, with bits 31:4 zero. A read of offset 0x8 returns zero. The data is valid in the cycle after the read strobe.
- R8: If an event and a pending-register clear hit the same bit in the same cycle, the bit ends up set.
- R9: A write to any other offset changes no register, and a read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| evt_i | input | 4 | Event pulses, one per source |
| irq_o | output | 4 | Level interrupt lines |

## Verification
The hardest case to reach from the ports is an event and a software clear that land on the same pending bit in the same clock cycle. The stimulus drives the event pulse and the clear write on the same falling edge, so both are sampled together. It then reads the pending register to confirm the bit survived. Clears and test writes are also issued with mixed bit patterns, and a mask write carries junk in its upper bits, so that bits meant to be unaffected are observed through reads and interrupt lines.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int NUM_SRC = 4;
  localparam int DATA_W  = 32;

  typedef enum logic [1:0] {
    SRC_TX_WM  = 2'd0,
    SRC_RX_WM  = 2'd1,
    SRC_TX_MT  = 2'd2,
    SRC_RX_OVF = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_PENDING = 2'd1,
    SEL_MASK    = 2'd2,
    SEL_TEST    = 2'd3
  } sel_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int OFF_PENDING = 'h0,
  parameter int OFF_MASK    = 'h4,
  parameter int OFF_TEST    = 'h8
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_pending,
  output logic              wr_mask,
  output logic              wr_test,
  output sel_e              sel
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PENDING);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_TEST = ADDR_W'(OFF_TEST);

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr == A_PEND)      sel = SEL_PENDING;
    else if (bus_addr == A_MASK) sel = SEL_MASK;
    else if (bus_addr == A_TEST) sel = SEL_TEST;
  end

  assign wr_pending = bus_wr && (sel == SEL_PENDING);
  assign wr_mask    = bus_wr && (sel == SEL_MASK);
  assign wr_test    = bus_wr && (sel == SEL_TEST);
endmodule

// File: rtl/irq_pending_bit.sv
module irq_pending_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  // Hardware event and software set both dominate a clear.
  always_comb begin
    q_en = evt_i || set_i || clr_i;
    q_d  = evt_i || set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 1'b0;
    else if (q_en) q_o <= q_d;
  end

  // R2, R8: an event always leaves the bit set
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> q_o);
  // R2: sticky without a clear
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
  // R3: a lone clear drops the bit
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i && !set_i) |=> !q_o);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb q_d = load_i ? d_i : q_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

  // R6: a mask write replaces every bit
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (q_o == $past(d_i)));
  // R6: no write, no change
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_regs_pkg::*;
#(
  parameter int W  = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_i,
  input  sel_e          sel_i,
  input  logic [W-1:0]  pending_i,
  input  logic [W-1:0]  mask_i,
  output logic [DW-1:0] rdata_o
);
  localparam int PAD = DW - W;
  logic [DW-1:0] rdata_d;

  always_comb begin
    unique case (sel_i)
      SEL_PENDING: rdata_d = {{PAD{1'b0}}, pending_i};
      SEL_MASK:    rdata_d = {{PAD{1'b0}}, mask_i};
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= rdata_d;
  end

  // R7: the write-only test register reads back zero
  a_r7_test_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel_i == SEL_TEST) |=> (rdata_o == '0));
  // R9: unmapped offsets read zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel_i == SEL_NONE) |=> (rdata_o == '0));
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [NUM_SRC-1:0] irq_o
);
  logic               wr_pending, wr_mask, wr_test;
  sel_e               sel;
  logic [NUM_SRC-1:0] pending_q;
  logic [NUM_SRC-1:0] mask_q;

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wr_pending (wr_pending),
    .wr_mask    (wr_mask),
    .wr_test    (wr_test),
    .sel        (sel)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_pending_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt_i[i]),
      .clr_i (wr_pending && bus_wdata[i]),
      .set_i (wr_test && bus_wdata[i]),
      .q_o   (pending_q[i])
    );
  end

  irq_mask_reg #(.W(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (wr_mask),
    .d_i    (bus_wdata[NUM_SRC-1:0]),
    .q_o    (mask_q)
  );

  irq_read_mux #(.W(NUM_SRC), .DW(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_i      (bus_rd),
    .sel_i     (sel),
    .pending_i (pending_q),
    .mask_i    (mask_q),
    .rdata_o   (bus_rdata)
  );

  assign irq_o = pending_q & mask_q;

  // R4: a test write raises every selected bit
  a_r4_test_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_test |=> ((pending_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));
  // R5: a line cannot rise without an event, a test write or a mask write
  a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0 && $past(irq_o) == '0) |-> ($past(evt_i) != '0 || $past(wr_test) || $past(wr_mask)));
endmodule

// File: tb/tb_irq_state_regs.sv
module tb_irq_state_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  evt_i = '0;
  logic [3:0]  irq_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #5 clk = ~clk;

  irq_state_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_i(evt_i), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: read data is registered at the edge that samples bus_rd.
  always @(posedge clk) begin
    if (bus_rd && rst_n) begin
      #2;
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(logic [3:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {28'd0, irq_o}, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rd(12'h0, 32'h0, "R1 pending reset");
    rd(12'h4, 32'h0, "R1 mask reset");

    pulse(4'b0100);
    rd(12'h0, 32'h4, "R2 tx-empty sticky");
    pulse(4'b1001);
    rd(12'h0, 32'hD, "R2 tx-wm and rx-ovf");
    check("R5 masked off", {28'd0, irq_o}, 32'h0);

    wr(12'h4, 32'h5);
    check("R5 irq after mask 0x5", {28'd0, irq_o}, 32'h5);
    rd(12'h4, 32'h5, "R6 mask readback");
    wr(12'h4, 32'hABCDE008);
    check("R6 mask replaced irq", {28'd0, irq_o}, 32'h8);
    rd(12'h4, 32'h8, "R7 mask upper bits zero");

    wr(12'h0, 32'h1);
    rd(12'h0, 32'hC, "R3 clear bit0 only");
    wr(12'h8, 32'h3);
    rd(12'h0, 32'hF, "R4 test sets bits 1:0");
    rd(12'h8, 32'h0, "R7 test reads zero");

    // R8: event on bit 1 and clear of bit 1 in the same cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h0; bus_wdata = 32'h2; evt_i = 4'b0010;
    @(negedge clk);
    bus_wr = 1'b0; evt_i = '0;
    rd(12'h0, 32'hF, "R8 event beats clear");

    wr(12'h0, 32'hF);
    rd(12'h0, 32'h0, "R3 clear all");
    check("R5 irq low after clear", {28'd0, irq_o}, 32'h0);

    wr(12'hC, 32'hF);
    rd(12'hC, 32'h0, "R9 unmapped reads zero");
    rd(12'h0, 32'h0, "R9 pending untouched");
    rd(12'h4, 32'h8, "R9 mask untouched");

    wr(12'h4, 32'hF);
    wr(12'h8, 32'hF);
    check("R5 all lines high", {28'd0, irq_o}, 32'hF);
    wr(12'h0, 32'h6);
    check("R5 lines after partial clear", {28'd0, irq_o}, 32'h9);

    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R7 read responses: got %0d missing expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule